// File: doc/BRIEF.md
# Merging Store Buffer

This block sits between a write-through cache and the next memory level. Every store the processor issues must also reach memory, so it is accepted into a small queue of block-sized entries and the processor carries on in the same cycle. Each entry holds a block address, one data word per word slot of the block and a per-word valid mask. A later store to a block that already has a waiting entry is folded into that entry, so one memory write carries several stores.

Entries leave in arrival order, one at a time, over a request/acknowledge port. The write carries the block address, the whole block of data and a word-enable mask taken from the entry's valid bits. Once an entry has been picked for draining it accepts no further stores, so the presented write stays fixed until acknowledged. Stores whose address falls in a configurable I/O window are never folded together; each one gets its own entry and keeps its place in the order.

The processor is held off (the ready output drops) only when every entry is in use and the store cannot be folded into any of them.

Top module: `merge_wbuf`

## Requirements
- R1: After reset `mem_req` is low and `st_ready` is high.
- R2: A store is taken in the cycle `st_valid` and `st_ready` are both high, whatever the state of the memory port; up to ENTRIES stores to distinct blocks are taken with no drain at all.
- R3: A store that is not in the I/O window, whose block (address bits above the low log2(WORDS) bits) matches a waiting entry that has not been picked, is folded into that entry: word slot k (the low address bits) gets the data, `mem_wen` bit k is set, and the data sits at `mem_data[k*DATA_W +: DATA_W]`. A later store to the same slot replaces the earlier value.
- R4: When all entries are in use, `st_ready` is low for a store that cannot be folded and high for one that can.
- R5: A store with `(addr & IO_MASK) == IO_BASE` is never folded and never receives folds; each takes its own entry, even for the same block and an empty slot.
- R6: Entries are written to memory oldest first.
- R7: While `mem_req` is high and `mem_ack` low, `mem_addr`, `mem_wen` and `mem_data` hold still; the entry is retired on the cycle both are high.
- R8: A store to the block of the entry being drained takes a new entry and leaves the drained write unchanged.
- R9: `mem_req` rises on the second clock edge after a store enters an idle, empty buffer, and after each acknowledge it is low for exactly one cycle before the next entry is presented.
- R10: When the buffer is full and an entry is acknowledged, a store that needs a new entry is refused in that cycle and accepted in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered by the processor |
| st_addr | input | ADDR_W | Word address of the store |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | Store taken this cycle when high |
| mem_req | output | 1 | Block write to memory pending |
| mem_addr | output | ADDR_W-log2(WORDS) | Block address of the write |
| mem_wen | output | WORDS | Word enables of the write |
| mem_data | output | WORDS*DATA_W | Block data, word k in slice k |
| mem_ack | input | 1 | Memory takes the write this cycle |

## Verification
A wrong entry count or pointer shows up as a refused store when free space exists or as a drain in the wrong order, visible at `st_ready` in the same cycle or at the next presented write. A wrong merge target or a missed lock shows as a word enable or data slice that differs from the stores sent, seen when that entry reaches the memory port, typically a few cycles later. Lock failures also show as a presented write that changes while unacknowledged, caught on the very next edge.

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int ENTRIES = 4,
  parameter int WORDS = 4,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hF000,
  parameter logic [ADDR_W-1:0] IO_MASK = 16'hF000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     st_valid,
  input  logic [ADDR_W-1:0]        st_addr,
  input  logic [DATA_W-1:0]        st_data,
  output logic                     st_ready,
  output logic                     mem_req,
  output logic [ADDR_W-$clog2(WORDS)-1:0] mem_addr,
  output logic [WORDS-1:0]         mem_wen,
  output logic [WORDS*DATA_W-1:0]  mem_data,
  input  logic                     mem_ack
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic [BLK_W-1:0]        blk_q [ENTRIES];
  logic [WORDS*DATA_W-1:0] dat_q [ENTRIES];
  logic [WORDS-1:0]        msk_q [ENTRIES];
  logic [ENTRIES-1:0]      vld_q, io_q, hit_vec;
  logic [PTR_W-1:0]        head_q, tail_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    busy_q;

  logic [BLK_W-1:0] st_blk;
  logic [OFF_W-1:0] st_off;
  logic [WORDS-1:0] st_sel;
  logic st_io, hit, full, acc, do_alloc, do_merge, pop;

  assign st_blk = st_addr[ADDR_W-1:OFF_W];
  assign st_off = st_addr[OFF_W-1:0];
  assign st_sel = {{(WORDS-1){1'b0}}, 1'b1} << st_off;
  assign st_io  = (st_addr & IO_MASK) == IO_BASE;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      hit_vec[i] = vld_q[i] && !io_q[i] && !st_io && (blk_q[i] == st_blk)
                   && !(busy_q && head_q == PTR_W'(i));
  end

  assign hit      = |hit_vec;
  assign full     = cnt_q == CNT_W'(ENTRIES);
  assign st_ready = hit || !full;
  assign acc      = st_valid && st_ready;
  assign do_alloc = acc && !hit;
  assign do_merge = acc && hit;
  assign pop      = busy_q && mem_ack;

  assign mem_req  = busy_q;
  assign mem_addr = blk_q[head_q];
  assign mem_wen  = msk_q[head_q];
  assign mem_data = dat_q[head_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      io_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        blk_q[i] <= '0;
        dat_q[i] <= '0;
        msk_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (pop && head_q == PTR_W'(i)) vld_q[i] <= 1'b0;
        if (do_alloc && tail_q == PTR_W'(i)) begin
          vld_q[i] <= 1'b1;
          io_q[i]  <= st_io;
          blk_q[i] <= st_blk;
          msk_q[i] <= st_sel;
          dat_q[i][st_off*DATA_W +: DATA_W] <= st_data;
        end else if (do_merge && hit_vec[i]) begin
          msk_q[i] <= msk_q[i] | st_sel;
          dat_q[i][st_off*DATA_W +: DATA_W] <= st_data;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (pop) head_q <= (head_q == PTR_W'(ENTRIES-1)) ? '0 : head_q + 1'b1;
      if (do_alloc) tail_q <= (tail_q == PTR_W'(ENTRIES-1)) ? '0 : tail_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(do_alloc) - CNT_W'(pop);
      if (pop) busy_q <= 1'b0;
      else if (!busy_q && cnt_q != '0) busy_q <= 1'b1;
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wen) && $stable(mem_data));

  // R9
  drain_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req);

  // R3
  wen_some_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_wen != '0);

  // R3
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R5
  io_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && st_io && !pop |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ENTRIES));
endmodule

// File: tb/merge_wbuf_tb.sv
module merge_wbuf_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0;
  logic [15:0] st_addr = '0;
  logic [15:0] st_data = '0;
  logic st_ready, mem_req, mem_ack;
  logic [13:0] mem_addr;
  logic [3:0]  mem_wen;
  logic [63:0] mem_data;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  merge_wbuf u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_ready(st_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_wen(mem_wen), .mem_data(mem_data), .mem_ack(mem_ack)
  );

  // {addr, data, expected ready}
  localparam logic [32:0] STIM [11] = '{
    {16'h0010, 16'h1111, 1'b1},   // R2 new entry
    {16'h0011, 16'h2222, 1'b1},   // R3 fold, entry not yet picked
    {16'h0012, 16'h3333, 1'b1},   // R8 block being drained: new entry
    {16'h0020, 16'h4444, 1'b1},
    {16'h0013, 16'h5555, 1'b1},   // R3 fold into second entry
    {16'hF000, 16'h6666, 1'b1},   // R5 I/O entry, buffer now full
    {16'h0021, 16'h7777, 1'b1},   // R4 full but foldable
    {16'hF001, 16'h8888, 1'b0},   // R4 R5 I/O never folds: refused
    {16'h0030, 16'h9999, 1'b0},   // R4 new block refused
    {16'h0022, 16'hAAAA, 1'b1},
    {16'h0020, 16'hBBBB, 1'b1}    // R3 overwrite of slot
  };

  // {block, wen, data}
  localparam logic [81:0] DRAIN [4] = '{
    {14'h0004, 4'b0011, 64'h0000_0000_2222_1111},
    {14'h0004, 4'b1100, 64'h5555_3333_0000_0000},
    {14'h0008, 4'b0111, 64'h0000_AAAA_7777_BBBB},
    {14'h3C00, 4'b0001, 64'h0000_0000_0000_6666}
  };

  function automatic logic [63:0] expand(input logic [3:0] w);
    for (int k = 0; k < 4; k++) expand[k*16 +: 16] = {16{w[k]}};
  endfunction

  task automatic check(input bit ok, input string req, input logic [81:0] act, input logic [81:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic store(input logic [15:0] a, input logic [15:0] d, input bit exp_rdy, input string req);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    #1;
    check(st_ready == exp_rdy, req, 82'(st_ready), 82'(exp_rdy));
    @(posedge clk);
  endtask

  task automatic idle_in();
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic drain(input logic [13:0] blk, input logic [3:0] wen, input logic [63:0] d, input string req);
    logic [81:0] first;
    int n = 0;
    @(negedge clk);
    while (!mem_req && n < 50) begin @(negedge clk); n++; end
    check(mem_req, req, 82'(mem_req), 82'(1));
    check(mem_addr == blk && mem_wen == wen, req, {mem_addr, mem_wen, 64'h0}, {blk, wen, 64'h0});
    check((mem_data & expand(wen)) == d, req, 82'(mem_data & expand(wen)), 82'(d));
    first = {mem_addr, mem_wen, mem_data};
    @(negedge clk);
    @(negedge clk);
    // R7 held while unacknowledged
    check({mem_req, mem_addr, mem_wen, mem_data} == {1'b1, first}, "R7", {mem_addr, mem_wen, mem_data}, first);
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    // R9 one idle cycle after acknowledge
    check(!mem_req, "R9", 82'(mem_req), 82'(0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mem_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!mem_req, "R1", 82'(mem_req), 82'(0));
    check(st_ready, "R1", 82'(st_ready), 82'(1));

    for (int v = 0; v < 11; v++)
      store(STIM[v][32:17], STIM[v][16:1], STIM[v][0], "R2 R3 R4 R5 R8");
    idle_in();
    // R6 R3 R8 R5 oldest first
    for (int v = 0; v < 4; v++)
      drain(DRAIN[v][81:68], DRAIN[v][67:64], DRAIN[v][63:0], "R6");

    // R9 request timing from empty
    repeat (2) @(negedge clk);
    store(16'h0040, 16'h1234, 1'b1, "R2");
    @(negedge clk);
    st_valid = 1'b0;
    check(!mem_req, "R9", 82'(mem_req), 82'(0));
    @(negedge clk);
    check(mem_req, "R9", 82'(mem_req), 82'(1));
    drain(14'h0010, 4'b0001, 64'h1234, "R9");

    // R5 same I/O block, four separate entries; R10 full with drain
    store(16'hF004, 16'hA004, 1'b1, "R5");
    store(16'hF005, 16'hA005, 1'b1, "R5");
    store(16'hF006, 16'hA006, 1'b1, "R5");
    store(16'hF007, 16'hA007, 1'b1, "R5");
    @(negedge clk);
    st_valid = 1'b1; st_addr = 16'hF008; st_data = 16'hA008; mem_ack = 1'b1;
    #1;
    check(mem_req && mem_addr == 14'h3C01 && mem_wen == 4'b0001, "R10",
          {mem_req, mem_addr, mem_wen}, {1'b1, 14'h3C01, 4'b0001});
    check(!st_ready, "R10", 82'(st_ready), 82'(0));
    @(negedge clk);
    mem_ack = 1'b0;
    #1;
    check(st_ready, "R10", 82'(st_ready), 82'(1));
    @(negedge clk);
    st_valid = 1'b0;
    drain(14'h3C01, 4'b0010, 64'h0000_0000_A005_0000, "R5");
    drain(14'h3C01, 4'b0100, 64'h0000_A006_0000_0000, "R5");
    drain(14'h3C01, 4'b1000, 64'hA007_0000_0000_0000, "R5");
    drain(14'h3C02, 4'b0001, 64'h0000_0000_0000_A008, "R10");

    repeat (3) @(negedge clk);
    check(!mem_req && st_ready, "R6", {mem_req, st_ready}, 82'b01);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule